// File: doc/BRIEF.md
# Pulse Width to Symbol Demodulator

This block turns a stream of pulse-width-modulated frames back into M-bit symbols. It runs on the slot clock that the transmitter used to build each frame: 2^M counting slots followed by a few guard slots. The pulse input is first passed through a two-flop synchroniser. After that, a saturating counter adds one for every slot in which the synchronised pulse is high.

Frame boundaries arrive on a one-cycle frame-start strobe. On a boundary cycle the controller copies the running count into the output register, raises a one-cycle valid strobe and restarts the counter, so each frame is measured on its own. The held symbol is meant to drive a DAC directly, which produces a stepped, sample-and-hold style waveform. Clock recovery and the analogue back end are outside the block.

The controller has two states. `ST_WAIT` is entered at reset and holds the counter cleared. Its only transition is *first-boundary* (frame-start seen), which leads to `ST_RUN`. In `ST_RUN`, each frame-start takes the *report* transition back into `ST_RUN`: the symbol is latched, the strobe is raised and the counter restarts. Only reset leaves `ST_RUN`.

Top module: `pwm_symbol_demod`

## Requirements
- R1: The pulse input reaches the counter through two register stages. A level sampled at slot edge k is counted at edge k+2, so a pulse occupying the last two slots of a frame is credited to the following frame.
- R2: While no boundary occurs, the count rises by exactly one on each slot edge at which the synchronised pulse is high, and holds otherwise.
- R3: The count saturates at 2^M-1 (all ones) and stays there until the next boundary.
- R4: On a frame-start cycle in `ST_RUN`, the count accumulated before that cycle becomes the symbol. In the same cycle the counter restarts at 1 if the synchronised pulse is high on that cycle, and at 0 if not.
- R5: The first frame-start after reset produces no valid strobe and leaves the symbol unchanged. Pulses seen before it are discarded.
- R6: The valid strobe is high for exactly the one cycle after each frame-start in `ST_RUN`, and low on every other cycle.
- R7: The symbol holds its value on every cycle without a valid strobe.
- R8: Reset sets the symbol to 0 and the strobe to 0, and returns the controller to `ST_WAIT`.
- R9: Take a frame of F = 2^M + G slots in which the pulse is high from slot 0 for W slots, with W ≤ F-2, plus T ≤ 2 slots carried over from the previous frame's tail. The reported symbol is min(W+T, 2^M-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Asynchronous pulse-width-modulated input |
| frame_start | input | 1 | One-cycle strobe marking slot 0 of each frame |
| symbol_o | output | SYM_W | Recovered symbol, held between boundaries |
| symbol_vld_o | output | 1 | One-cycle strobe when a new symbol is latched |

## Verification
The assertions check the counter on every cycle: its single-step increment, its hold when the pulse is low, and its saturation at all ones. They also check that the counter restarts on a boundary, that the symbol holds between strobes, and that no strobe appears while the controller is in `ST_WAIT`. Three behaviours depend on stimulus history and are shown only by the bench's scenarios. The first is the two-slot synchroniser delay, visible when a pulse tail spills into the next frame. The second is the discarding of pre-frame noise at the first boundary. The third is the full sweep of pulse widths from zero up to past saturation, with each result compared against min(W+T, 2^M-1).

// File: rtl/pwm_demod_pkg.sv
package pwm_demod_pkg;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } demod_state_e;

endpackage

// File: rtl/pwm_pulse_sync.sv
module pwm_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_slot_counter.sv
module pwm_slot_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= CNT_W'(inc);
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R3
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/pwm_frame_ctrl.sv
module pwm_frame_ctrl
    import pwm_demod_pkg::*;
#(
    parameter int SYM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [SYM_W-1:0] cnt,
    output logic             cnt_clr,
    output logic [SYM_W-1:0] symbol_o,
    output logic             symbol_vld_o
);

    demod_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (frame_start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_WAIT;
        endcase
    end

    assign cnt_clr = frame_start || (state_q == ST_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            symbol_o     <= '0;
            symbol_vld_o <= 1'b0;
        end else if (frame_start && state_q == ST_RUN) begin
            symbol_o     <= cnt;
            symbol_vld_o <= 1'b1;
        end else begin
            symbol_vld_o <= 1'b0;
        end
    end

    // R5
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> !symbol_vld_o);

    // R7
    sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !symbol_vld_o |-> $stable(symbol_o));

    // R6
    vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        symbol_vld_o |-> $past(frame_start));

endmodule

// File: rtl/pwm_symbol_demod.sv
module pwm_symbol_demod #(
    parameter int SYM_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             frame_start,
    output logic [SYM_W-1:0] symbol_o,
    output logic             symbol_vld_o
);

    logic             pulse_s;
    logic             cnt_clr;
    logic [SYM_W-1:0] slot_cnt;

    pwm_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pulse_in),
        .dout  (pulse_s)
    );

    pwm_slot_counter #(.CNT_W(SYM_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (pulse_s),
        .cnt   (slot_cnt)
    );

    pwm_frame_ctrl #(.SYM_W(SYM_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .cnt          (slot_cnt),
        .cnt_clr      (cnt_clr),
        .symbol_o     (symbol_o),
        .symbol_vld_o (symbol_vld_o)
    );

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (slot_cnt == SYM_W'($past(pulse_s))));

endmodule

// File: tb/pwm_symbol_demod_tb.sv
module pwm_symbol_demod_tb_top;

    localparam int M     = 4;
    localparam int GUARD = 4;
    localparam int F     = (1 << M) + GUARD;
    localparam int SMAX  = (1 << M) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pulse_in = 1'b0;
    logic         frame_start = 1'b0;
    logic [M-1:0] symbol_o;
    logic         symbol_vld_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_sym = 0;
    int prev_exp = 0;
    int prev_tail = 0;
    bit have_prev = 1'b0;

    always #4 clk = ~clk;

    pwm_symbol_demod #(.SYM_W(M), .SYNC_STAGES(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_in     (pulse_in),
        .frame_start  (frame_start),
        .symbol_o     (symbol_o),
        .symbol_vld_o (symbol_vld_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SMAX) ? SMAX : v;
    endfunction

    // one frame: high for slots 0..w-1 and for the last 'tail' slots
    task automatic run_frame(input int w, input int tail);
        for (int s = 0; s < F; s++) begin
            @(negedge clk);
            if (s == 1) begin
                if (have_prev) begin
                    chk(symbol_vld_o == 1'b1, "R6", int'(symbol_vld_o), 1);
                    chk(int'(symbol_o) == prev_exp, "R9", int'(symbol_o), prev_exp);
                    cur_sym = prev_exp;
                end else begin
                    chk(symbol_vld_o == 1'b0, "R5", int'(symbol_vld_o), 0);
                    chk(int'(symbol_o) == cur_sym, "R5", int'(symbol_o), cur_sym);
                end
            end else begin
                chk(symbol_vld_o == 1'b0, "R6", int'(symbol_vld_o), 0);
                chk(int'(symbol_o) == cur_sym, "R7", int'(symbol_o), cur_sym);
            end
            frame_start = (s == 0);
            pulse_in    = (s < w) || (s >= F - tail);
        end
        prev_exp  = sat(w + prev_tail);
        prev_tail = tail;
        have_prev = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(symbol_o == '0, "R8", int'(symbol_o), 0);
        chk(symbol_vld_o == 1'b0, "R8", int'(symbol_vld_o), 0);
        rst_n = 1'b1;
        // pre-frame noise that must be discarded (R5)
        pulse_in = 1'b1;
        repeat (5) @(negedge clk);
        pulse_in = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R2 R3 R9: width sweep, saturation past 2^M-1
        for (int w = 0; w <= F - 2; w++) run_frame(w, 0);
        // R1: tail slots carried into the next frame
        run_frame(2, 2);
        run_frame(3, 1);
        run_frame(0, 2);
        run_frame(SMAX, 2);
        run_frame(4, 0);
        run_frame(0, 0);

        // R8: reset in the middle of a frame
        @(negedge clk);
        frame_start = 1'b0;
        pulse_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(symbol_o == '0, "R8", int'(symbol_o), 0);
        chk(symbol_vld_o == 1'b0, "R8", int'(symbol_vld_o), 0);
        pulse_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cur_sym = 0;
        have_prev = 1'b0;
        prev_tail = 0;
        repeat (3) @(negedge clk);
        run_frame(6, 0);
        run_frame(1, 0);
        run_frame(0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule